// File: doc/BRIEF.md
# Receive Buffer with Per-Character Error Tags

This block sits between a serial receiver's deserializer and the host's read port. The deserializer hands over each received character together with three error flags (parity, framing and break, in any assignment the deserializer chooses). The block stores them side by side in a 64-entry, 11-bit-wide memory. The oldest unread entry is presented at all times as the holding value, and its error flags are presented as status bits. When the host reads, the next entry and its own flags appear on the following cycle.

The host is told that data is waiting in two ways. A level interrupt rises when the fill count reaches a selectable threshold; outside buffered mode the threshold is one character. A character-timeout interrupt covers data that stays below the threshold: it fires when data has sat unread, with no arrivals and no reads, for four character lengths plus twelve bit times. Bit times are counted on an external tick enable. A mode input selects the 64-entry buffered mode or a single-slot mode, and any change of mode empties the store.

The timeout logic is a three-state machine. TMO_IDLE holds while the store is empty or single-slot mode is selected. IDLE→COUNT happens when a character lands in an empty store in buffered mode. COUNT→COUNT restarts the tick count on any accepted write or read. COUNT→FIRED happens on the tick that completes the limit. FIRED→COUNT happens on any write or read that leaves data stored. Any state goes to IDLE when the store becomes empty or buffered mode is left.

Top module: `rx_tag_fifo`

## Requirements
- R1: In buffered mode (fifo_en=1) the store holds up to 64 entries of 8 data bits plus 3 flag bits, and `fill_count` reports the number held.
- R2: `hold_data` always shows the oldest unread character while the store is non-empty.
- R3: `hold_tags` shows the flags stored with the oldest unread character and reads 0 while empty; after a host read they show the next entry's flags on the following cycle.
- R4: A read strobe while empty leaves `fill_count` unchanged and `hold_data` equal to the last character read.
- R5: `data_ready` is high exactly when `fill_count` is non-zero; after reset the count, `data_ready` and `overrun` are 0.
- R6: `rx_irq` is high while `fill_count` is at or above the threshold. In buffered mode `trig_sel` 0/1/2/3 selects 8/16/56/60; in single-slot mode the threshold is 1.
- R7: With fifo_en=0 only one character is stored.
- R8: A write arriving while full (and not accompanied by a read) is dropped and sets `overrun`. The flag holds until a `stat_rd` pulse; if a set and a clear fall in the same cycle, the set wins.
- R9: In buffered mode, with data stored, `timeout_irq` rises once 4·(5+word_len)+12 consecutive `bit_tick` pulses pass with no accepted write or read.
- R10: Any accepted write or read restarts the timeout count and clears `timeout_irq`.
- R11: Both interrupts are forced low while `rx_int_en` is 0.
- R12: Any change of `fifo_en` empties the store on that clock edge; a write in that cycle is dropped without setting `overrun`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| fifo_en | input | 1 | 1 = 64-entry buffered mode, 0 = single slot |
| trig_sel | input | 2 | Interrupt threshold select (8/16/56/60) |
| word_len | input | 2 | Character length code, 5+word_len data bits |
| rx_int_en | input | 1 | Interrupt enable |
| bit_tick | input | 1 | One pulse per bit time |
| wr_valid | input | 1 | Character strobe from the deserializer |
| wr_data | input | 8 | Received character |
| wr_tags | input | 3 | Error flags of the character |
| rd_strobe | input | 1 | Host read of the holding value |
| stat_rd | input | 1 | Host read of status, clears overrun |
| hold_data | output | 8 | Oldest unread character |
| hold_tags | output | 3 | Error flags of the oldest unread character |
| fill_count | output | 7 | Entries held |
| data_ready | output | 1 | Store not empty |
| overrun | output | 1 | Sticky overflow flag |
| rx_irq | output | 1 | Threshold interrupt |
| timeout_irq | output | 1 | Character-timeout interrupt |

## Verification
Some rules are checked on every cycle. The count never exceeds the depth, and never exceeds one in single-slot mode. Overrun is sticky and is set by a write into a full store. An empty read keeps the holding value. A timeout is only reported while data is stored, and a read clears it. Other behaviours only show over a stretch of stimulus, and the bench's scenarios cover them. These are first-in-first-out order with the right flags following each byte, the exact tick on which the timeout fires for each word length, each threshold value, and the flush on a mode change.

// File: rtl/rxf_pkg.sv
package rxf_pkg;

    localparam int DATA_W = 8;
    localparam int TAG_W  = 3;

    typedef struct packed {
        logic [TAG_W-1:0]  tags;
        logic [DATA_W-1:0] data;
    } rx_entry_t;

    typedef enum logic [1:0] {
        TMO_IDLE  = 2'd0,
        TMO_COUNT = 2'd1,
        TMO_FIRED = 2'd2
    } tmo_state_e;

    function automatic int unsigned trig_level(input logic [1:0] sel);
        unique case (sel)
            2'd0:    return 8;
            2'd1:    return 16;
            2'd2:    return 56;
            default: return 60;
        endcase
    endfunction

    // four characters of (5 + code) bits, plus twelve bit times
    function automatic int unsigned tmo_limit(input logic [1:0] wl);
        return 4 * (5 + int'(wl)) + 12;
    endfunction

endpackage

// File: rtl/rxf_store.sv
module rxf_store
    import rxf_pkg::*;
#(
    parameter int DEPTH = 64,
    localparam int AW = $clog2(DEPTH),
    localparam int CW = AW + 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             flush,
    input  logic [CW-1:0]    cap,
    input  logic             wr_valid,
    input  rx_entry_t        wr_entry,
    input  logic             rd_req,
    output rx_entry_t        head,
    output logic [CW-1:0]    count,
    output logic             wr_acc,
    output logic             rd_do
);

    rx_entry_t      mem [DEPTH];
    logic [AW-1:0]  wr_ptr;
    logic [AW-1:0]  rd_ptr;

    function automatic logic [AW-1:0] bump(input logic [AW-1:0] p);
        return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    assign rd_do  = rd_req && (count != '0) && !flush;
    assign wr_acc = wr_valid && !flush && ((count < cap) || rd_do);
    assign head   = mem[rd_ptr];

    always_ff @(posedge clk) begin
        if (wr_acc) begin
            mem[wr_ptr] <= wr_entry;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
        end else if (flush) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
        end else begin
            if (wr_acc) wr_ptr <= bump(wr_ptr);
            if (rd_do)  rd_ptr <= bump(rd_ptr);
            count <= count + CW'(wr_acc) - CW'(rd_do);
        end
    end

endmodule

// File: rtl/rxf_timeout.sv
module rxf_timeout
    import rxf_pkg::*;
#(
    parameter int TICK_W = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              active,
    input  logic              restart,
    input  logic              bit_tick,
    input  logic [TICK_W-1:0] limit,
    output logic              fired
);

    tmo_state_e        state_q, state_d;
    logic [TICK_W-1:0] tcnt_q, tcnt_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= TMO_IDLE;
            tcnt_q  <= '0;
        end else begin
            state_q <= state_d;
            tcnt_q  <= tcnt_d;
        end
    end

    always_comb begin
        state_d = state_q;
        tcnt_d  = tcnt_q;
        if (!active) begin
            state_d = TMO_IDLE;
            tcnt_d  = '0;
        end else begin
            unique case (state_q)
                TMO_IDLE: begin
                    state_d = TMO_COUNT;
                    tcnt_d  = '0;
                end
                TMO_COUNT: begin
                    if (restart) begin
                        tcnt_d = '0;
                    end else if (bit_tick) begin
                        if (tcnt_q == limit - 1'b1) begin
                            state_d = TMO_FIRED;
                            tcnt_d  = '0;
                        end else begin
                            tcnt_d = tcnt_q + 1'b1;
                        end
                    end
                end
                TMO_FIRED: begin
                    if (restart) begin
                        state_d = TMO_COUNT;
                        tcnt_d  = '0;
                    end
                end
                default: begin
                    state_d = TMO_IDLE;
                    tcnt_d  = '0;
                end
            endcase
        end
    end

    assign fired = (state_q == TMO_FIRED);

endmodule

// File: rtl/rx_tag_fifo.sv
module rx_tag_fifo
    import rxf_pkg::*;
#(
    parameter int DEPTH  = 64,
    parameter int TICK_W = 6,
    localparam int CW    = $clog2(DEPTH) + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              fifo_en,
    input  logic [1:0]        trig_sel,
    input  logic [1:0]        word_len,
    input  logic              rx_int_en,
    input  logic              bit_tick,
    input  logic              wr_valid,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [TAG_W-1:0]  wr_tags,
    input  logic              rd_strobe,
    input  logic              stat_rd,
    output logic [DATA_W-1:0] hold_data,
    output logic [TAG_W-1:0]  hold_tags,
    output logic [CW-1:0]     fill_count,
    output logic              data_ready,
    output logic              overrun,
    output logic              rx_irq,
    output logic              timeout_irq
);

    logic              mode_q;
    logic              flush;
    logic [CW-1:0]     cap;
    logic [CW-1:0]     count;
    logic [CW-1:0]     nxt_count;
    logic [CW-1:0]     level;
    logic              wr_acc, rd_do, tmo_fired;
    rx_entry_t         head, in_entry;
    logic [DATA_W-1:0] last_q;

    assign flush    = (fifo_en != mode_q);
    assign cap      = fifo_en ? CW'(DEPTH) : CW'(1);
    assign in_entry = '{tags: wr_tags, data: wr_data};

    rxf_store #(.DEPTH(DEPTH)) u_store (
        .clk      (clk),
        .rst_n    (rst_n),
        .flush    (flush),
        .cap      (cap),
        .wr_valid (wr_valid),
        .wr_entry (in_entry),
        .rd_req   (rd_strobe),
        .head     (head),
        .count    (count),
        .wr_acc   (wr_acc),
        .rd_do    (rd_do)
    );

    assign nxt_count = flush ? '0 : count + CW'(wr_acc) - CW'(rd_do);

    rxf_timeout #(.TICK_W(TICK_W)) u_tmo (
        .clk      (clk),
        .rst_n    (rst_n),
        .active   (fifo_en && (nxt_count != '0)),
        .restart  (wr_acc || rd_do),
        .bit_tick (bit_tick),
        .limit    (TICK_W'(tmo_limit(word_len))),
        .fired    (tmo_fired)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mode_q  <= 1'b1;
            overrun <= 1'b0;
            last_q  <= '0;
        end else begin
            mode_q <= fifo_en;
            if (wr_valid && !wr_acc && !flush) begin
                overrun <= 1'b1;
            end else if (stat_rd) begin
                overrun <= 1'b0;
            end
            if (rd_do) begin
                last_q <= head.data;
            end
        end
    end

    assign level       = fifo_en ? CW'(trig_level(trig_sel)) : CW'(1);
    assign fill_count  = count;
    assign data_ready  = (count != '0);
    assign hold_data   = data_ready ? head.data : last_q;
    assign hold_tags   = data_ready ? head.tags : '0;
    assign rx_irq      = rx_int_en && (count >= level);
    assign timeout_irq = rx_int_en && tmo_fired;

endmodule

// File: rtl/rx_tag_fifo_chk.sv
module rx_tag_fifo_chk #(
    parameter int DEPTH = 64,
    localparam int CW   = $clog2(DEPTH) + 1
) (
    input logic          clk,
    input logic          rst_n,
    input logic          fifo_en,
    input logic          rx_int_en,
    input logic          wr_valid,
    input logic          rd_strobe,
    input logic          stat_rd,
    input logic [7:0]    hold_data,
    input logic [CW-1:0] fill_count,
    input logic          data_ready,
    input logic          overrun,
    input logic          timeout_irq
);

    AST_FILL_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        fill_count <= CW'(DEPTH)); // R1

    AST_SINGLE_SLOT: assert property (@(posedge clk) disable iff (!rst_n)
        (!fifo_en && $stable(fifo_en)) |-> (fill_count <= CW'(1))); // R7

    AST_EMPTY_READ_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_strobe && !data_ready && !wr_valid)
        |=> ($stable(hold_data) && fill_count == '0)); // R4

    AST_OVR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (overrun && !stat_rd) |=> overrun); // R8

    AST_OVR_SET: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_valid && fifo_en && $stable(fifo_en) && !rd_strobe
         && fill_count == CW'(DEPTH)) |=> overrun); // R8

    AST_TMO_HAS_DATA: assert property (@(posedge clk) disable iff (!rst_n)
        timeout_irq |-> data_ready); // R9

    AST_TMO_READ_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        (timeout_irq && rd_strobe) |=> !timeout_irq); // R10

endmodule

bind rx_tag_fifo rx_tag_fifo_chk #(.DEPTH(DEPTH)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .fifo_en     (fifo_en),
    .rx_int_en   (rx_int_en),
    .wr_valid    (wr_valid),
    .rd_strobe   (rd_strobe),
    .stat_rd     (stat_rd),
    .hold_data   (hold_data),
    .fill_count  (fill_count),
    .data_ready  (data_ready),
    .overrun     (overrun),
    .timeout_irq (timeout_irq)
);

// File: tb/test_rx_tag_fifo.sv
module test_rx_tag_fifo;

    localparam int CLK_PERIOD = 10;
    localparam int DEPTH      = 64;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       fifo_en = 1'b1;
    logic [1:0] trig_sel = 2'd0;
    logic [1:0] word_len = 2'd0;
    logic       rx_int_en = 1'b1;
    logic       bit_tick = 1'b0;
    logic       wr_valid = 1'b0;
    logic [7:0] wr_data = '0;
    logic [2:0] wr_tags = '0;
    logic       rd_strobe = 1'b0;
    logic       stat_rd = 1'b0;
    logic [7:0] hold_data;
    logic [2:0] hold_tags;
    logic [6:0] fill_count;
    logic       data_ready, overrun, rx_irq, timeout_irq;

    int n_checks = 0;
    int n_fail   = 0;

    // reference state
    logic [10:0] mq[$];
    logic [7:0]  m_last;
    logic        m_ovr, m_prev_en, m_fired;
    int          m_tc;

    always #(CLK_PERIOD/2) clk = ~clk;

    rx_tag_fifo i_rx_tag_fifo (
        .clk(clk), .rst_n(rst_n), .fifo_en(fifo_en), .trig_sel(trig_sel),
        .word_len(word_len), .rx_int_en(rx_int_en), .bit_tick(bit_tick),
        .wr_valid(wr_valid), .wr_data(wr_data), .wr_tags(wr_tags),
        .rd_strobe(rd_strobe), .stat_rd(stat_rd), .hold_data(hold_data),
        .hold_tags(hold_tags), .fill_count(fill_count), .data_ready(data_ready),
        .overrun(overrun), .rx_irq(rx_irq), .timeout_irq(timeout_irq)
    );

    function automatic int lvl_of(input logic [1:0] s);
        case (s)
            2'd0: return 8;
            2'd1: return 16;
            2'd2: return 56;
            default: return 60;
        endcase
    endfunction

    function automatic int lim_of(input logic [1:0] w);
        return 4 * (5 + int'(w)) + 12;
    endfunction

    task automatic chk(input string req, input int got, input int exp);
        n_checks++;
        if (got != exp) begin
            n_fail++;
            $display("FAIL %s: got %0d expected %0d at %0t", req, got, exp, $time);
        end
    endtask

    task automatic model_step();
        bit rd, acc, ovr_set, ev;
        int cap;
        rd = 0; acc = 0; ovr_set = 0;
        if (fifo_en != m_prev_en) begin
            mq.delete();
        end else begin
            cap = fifo_en ? DEPTH : 1;
            rd  = rd_strobe && (mq.size() > 0);
            acc = wr_valid && ((mq.size() < cap) || rd);
            if (rd) begin
                m_last = mq[0][7:0];
                void'(mq.pop_front());
            end
            if (acc) mq.push_back({wr_tags, wr_data});
            ovr_set = wr_valid && !acc;
        end
        m_prev_en = fifo_en;
        if (ovr_set) m_ovr = 1'b1;
        else if (stat_rd) m_ovr = 1'b0;
        ev = acc || rd;
        if (!fifo_en || mq.size() == 0) begin
            m_tc = 0; m_fired = 0;
        end else if (ev) begin
            m_tc = 0; m_fired = 0;
        end else if (!m_fired && bit_tick) begin
            if (m_tc == lim_of(word_len) - 1) begin
                m_fired = 1; m_tc = 0;
            end else begin
                m_tc++;
            end
        end
    endtask

    task automatic compare_all();
        int sz;
        sz = mq.size();
        chk("R1 fill_count", int'(fill_count), sz);
        chk("R5 data_ready", int'(data_ready), int'(sz != 0));
        chk("R2 hold_data", int'(hold_data), sz != 0 ? int'(mq[0][7:0]) : int'(m_last));
        chk("R3 hold_tags", int'(hold_tags), sz != 0 ? int'(mq[0][10:8]) : 0);
        chk("R8 overrun", int'(overrun), int'(m_ovr));
        chk("R6 rx_irq", int'(rx_irq),
            int'(rx_int_en && sz >= (fifo_en ? lvl_of(trig_sel) : 1)));
        chk("R9 timeout_irq", int'(timeout_irq), int'(rx_int_en && m_fired));
    endtask

    task automatic cycle();
        model_step();
        @(posedge clk);
        @(negedge clk);
        compare_all();
    endtask

    task automatic push(input logic [7:0] d, input logic [2:0] t);
        wr_valid = 1'b1; wr_data = d; wr_tags = t;
        cycle();
        wr_valid = 1'b0;
    endtask

    task automatic pull();
        rd_strobe = 1'b1;
        cycle();
        rd_strobe = 1'b0;
    endtask

    task automatic reflush();
        fifo_en = ~fifo_en; cycle();
        fifo_en = ~fifo_en; cycle();
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        n_fail++;
        n_checks++;
        $display("FAIL watchdog expired");
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        void'($urandom(32'd20240611));
        mq.delete(); m_last = '0; m_ovr = 0; m_prev_en = 1; m_fired = 0; m_tc = 0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R5 reset count", int'(fill_count), 0);
        chk("R5 reset ready", int'(data_ready), 0);
        chk("R5 reset overrun", int'(overrun), 0);

        // fill to the top, then one more
        for (int i = 0; i < DEPTH; i++) begin
            push(8'(i * 3 + 1), 3'(i));
            if (i == 7) chk("R6 level 8 reached", int'(rx_irq), 1);
        end
        chk("R1 full count", int'(fill_count), 64);
        push(8'hEE, 3'd7);
        chk("R8 overrun on full", int'(overrun), 1);
        chk("R8 dropped write", int'(fill_count), 64);
        stat_rd = 1'b1; cycle(); stat_rd = 1'b0;
        chk("R8 cleared by status read", int'(overrun), 0);

        // drain, checking order and flags
        for (int i = 0; i < DEPTH; i++) begin
            chk("R2 order", int'(hold_data), (i * 3 + 1) % 256);
            chk("R3 flags", int'(hold_tags), i % 8);
            pull();
        end
        pull();
        chk("R4 empty read keeps last", int'(hold_data), (63 * 3 + 1) % 256);
        chk("R4 empty read count", int'(fill_count), 0);

        // timeout, each word length
        for (int w = 0; w < 4; w++) begin
            word_len = 2'(w);
            push(8'hA0 + 8'(w), 3'd1);
            bit_tick = 1'b1;
            for (int k = 0; k < lim_of(2'(w)) - 1; k++) cycle();
            chk("R9 not yet", int'(timeout_irq), 0);
            cycle();
            chk("R9 fires at limit", int'(timeout_irq), 1);
            rx_int_en = 1'b0; cycle();
            chk("R11 timeout masked", int'(timeout_irq), 0);
            chk("R11 level masked", int'(rx_irq), 0);
            rx_int_en = 1'b1; cycle();
            push(8'h55, 3'd2);
            chk("R10 write restarts", int'(timeout_irq), 0);
            bit_tick = 1'b0;
            pull(); pull();
        end

        // single-slot mode and flush on mode change
        push(8'h11, 3'd0); push(8'h12, 3'd0);
        fifo_en = 1'b0; cycle();
        chk("R12 flush on mode change", int'(fill_count), 0);
        chk("R12 no overrun from flush", int'(overrun), 0);
        push(8'h21, 3'd4); push(8'h22, 3'd5); push(8'h23, 3'd6);
        chk("R7 single slot", int'(fill_count), 1);
        chk("R7 holds first", int'(hold_data), 8'h21);
        chk("R6 threshold one", int'(rx_irq), 1);
        stat_rd = 1'b1; cycle(); stat_rd = 1'b0;
        fifo_en = 1'b1; cycle();

        // every threshold
        for (int s = 0; s < 4; s++) begin
            trig_sel = 2'(s);
            reflush();
            for (int i = 0; i < lvl_of(2'(s)) - 1; i++) push(8'(i), 3'd0);
            chk("R6 below threshold", int'(rx_irq), 0);
            push(8'hFF, 3'd3);
            chk("R6 at threshold", int'(rx_irq), 1);
            pull();
            chk("R6 falls below", int'(rx_irq), 0);
        end
        reflush();

        // constrained random phases
        for (int ph = 0; ph < 16; ph++) begin
            int wp, rp;
            wp = (ph % 2 == 0) ? 85 : 30;
            rp = (ph % 2 == 0) ? 20 : 70;
            trig_sel = 2'($urandom_range(0, 3));
            word_len = 2'($urandom_range(0, 3));
            for (int c = 0; c < 250; c++) begin
                wr_valid  = ($urandom_range(0, 99) < wp);
                wr_data   = 8'($urandom);
                wr_tags   = 3'($urandom);
                rd_strobe = ($urandom_range(0, 99) < rp);
                stat_rd   = ($urandom_range(0, 99) < 8);
                bit_tick  = ($urandom_range(0, 99) < 70);
                rx_int_en = ($urandom_range(0, 99) < 92);
                if ($urandom_range(0, 299) == 0) fifo_en = ~fifo_en;
                cycle();
            end
        end
        wr_valid = 0; rd_strobe = 0; stat_rd = 0; bit_tick = 0;
        cycle();

        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

endmodule